// File: doc/BRIEF.md
# UART Multiprocessor Receive Filter

This block holds the 8-bit control word of an asynchronous serial port and the receive-side logic that the control word governs. A CPU writes the word and reads it back. The word carries three groups of settings: the interrupt enables, the transmit and receive enables, and a two-bit prescaler code that goes to an external baud-rate counter. It also carries a wake-up enable for multiprocessor addressing.

A receive-frame interface presents each completed frame as a single-cycle pulse. The pulse comes with the data byte, the multiprocessor (address) bit, a framing-error indication and an overrun indication. The block decides whether the frame is taken. A frame that is taken loads the data register and sets the sticky status flags. A frame that is discarded leaves no trace. While wake-up mode is armed, every data frame (address bit 0) is dropped silently. The first address frame (address bit 1) is taken, and in the same cycle hardware disarms wake-up mode. Each interrupt request output is the AND of a status flag and its enable.

Top module: `uart_mp_rx_filter`

## Requirements
- R1: After reset the control word reads 0x00, all status flags are 0, the data register is 0 and every interrupt request is low.
- R2: Bit 2 of the control word is reserved. It always reads 0, and writing 1 to it has no effect.
- R3: The prescaler code output equals control bits 1:0. Code 0 is the undivided clock, 1 is clock/4, 2 is clock/16 and 3 is clock/64.
- R4: The transmit request is high exactly when the transmit-data-empty input is high and the transmit-interrupt enable (bit 7) is set.
- R5: The receive-interrupt enable (bit 6) gates two requests. The receive request is the receive-full flag AND bit 6. The error request is (framing flag OR overrun flag) AND bit 6.
- R6: Wake-up mode is armed when bit 3 is set, the multiprocessor-mode input is high and the asynchronous-mode input is high. While it is armed, a frame with address bit 0 changes neither the data register nor any status flag, even if it reports a framing error or an overrun.
- R7: While wake-up mode is armed, a frame with address bit 1 is taken. In that same cycle, bit 3 clears, the data register loads, the receive-full flag sets, and the error flags set according to the frame's indications.
- R8: When the multiprocessor-mode input or the asynchronous-mode input is low, bit 3 has no effect. Every frame is taken, and bit 3 keeps its value.
- R9: While the receive enable (bit 4) is 0, frames change neither the data register nor any flag.
- R10: If a CPU write and the hardware clear of bit 3 fall in the same cycle, bit 3 ends up 0 and the other bits take the written value.
- R11: Status flags stay set until their own clear strobe is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R12: The transmit-enable and receive-enable outputs follow control bits 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the control word |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Control word readback |
| mp_mode_i | input | 1 | Multiprocessor mode selected |
| async_mode_i | input | 1 | Asynchronous mode selected |
| tx_empty_i | input | 1 | Transmit data register empty |
| frm_valid_i | input | 1 | Completed frame pulse |
| frm_data_i | input | 8 | Frame data byte |
| frm_mpb_i | input | 1 | Frame multiprocessor bit |
| frm_ferr_i | input | 1 | Frame framing error |
| frm_ovr_i | input | 1 | Frame overrun |
| clr_rxfull_i | input | 1 | Clear strobe, receive-full flag |
| clr_ferr_i | input | 1 | Clear strobe, framing flag |
| clr_ovr_i | input | 1 | Clear strobe, overrun flag |
| rx_data_o | output | 8 | Received data register |
| rxfull_o | output | 1 | Receive-full flag |
| ferr_o | output | 1 | Framing-error flag |
| ovr_o | output | 1 | Overrun flag |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| clk_sel_o | output | 2 | Prescaler code |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_err_o | output | 1 | Receive error interrupt request |

## Verification
The assertions check several properties on every cycle. The reserved bit always reads 0, and each request equals its flag ANDed with its enable. A dropped or disabled frame leaves the data register unchanged. An armed address frame always disarms bit 3, and flags never fall without their clear strobe. Only the bench scenarios show the things a per-cycle check cannot pin down. One is the sequence in which data frames are skipped and the later address frame is taken with its error flags. Another is that bit 3 survives when multiprocessor mode is off. The last is the resolution of a write that collides with the hardware clear.

// File: rtl/uart_mpf_pkg.sv
package uart_mpf_pkg;
   localparam int unsigned CW_W   = 8;
   localparam int unsigned B_TIE  = 7;
   localparam int unsigned B_RIE  = 6;
   localparam int unsigned B_TE   = 5;
   localparam int unsigned B_RE   = 4;
   localparam int unsigned B_MPIE = 3;
   localparam int unsigned B_RSV  = 2;
   localparam int unsigned CKS_W  = 2;

   typedef struct packed {
      logic             tie;
      logic             rie;
      logic             te;
      logic             re;
      logic             mpie;
      logic [CKS_W-1:0] cks;
   } ctrl_t;

   function automatic ctrl_t unpack_ctrl(input logic [CW_W-1:0] w);
      ctrl_t c;
      c.tie  = w[B_TIE];
      c.rie  = w[B_RIE];
      c.te   = w[B_TE];
      c.re   = w[B_RE];
      c.mpie = w[B_MPIE];
      c.cks  = w[CKS_W-1:0];
      return c;
   endfunction

   function automatic logic [CW_W-1:0] pack_ctrl(input ctrl_t c);
      logic [CW_W-1:0] w;
      w          = '0;
      w[B_TIE]   = c.tie;
      w[B_RIE]   = c.rie;
      w[B_TE]    = c.te;
      w[B_RE]    = c.re;
      w[B_MPIE]  = c.mpie;
      w[B_RSV]   = 1'b0;
      w[CKS_W-1:0] = c.cks;
      return w;
   endfunction
endpackage

// File: rtl/uart_mpf_ctrl_reg.sv
module uart_mpf_ctrl_reg
   import uart_mpf_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            we_i,
   input  logic [CW_W-1:0] wdata_i,
   input  logic            hw_clr_mpie_i,
   output ctrl_t           ctrl_o,
   output logic [CW_W-1:0] rdata_o
);
   ctrl_t ctrl_q, ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (we_i) ctrl_d = unpack_ctrl(wdata_i);
      // hardware disarm outranks a simultaneous software write
      if (hw_clr_mpie_i) ctrl_d.mpie = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= '0;
      else         ctrl_q <= ctrl_d;
   end

   assign ctrl_o  = ctrl_q;
   assign rdata_o = pack_ctrl(ctrl_q);
endmodule

// File: rtl/uart_mpf_rx_gate.sv
module uart_mpf_rx_gate
   import uart_mpf_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  ctrl_t             ctrl_i,
   input  logic              mp_mode_i,
   input  logic              async_mode_i,
   input  logic              frm_valid_i,
   input  logic [DATA_W-1:0] frm_data_i,
   input  logic              frm_mpb_i,
   input  logic              frm_ferr_i,
   input  logic              frm_ovr_i,
   input  logic              clr_rxfull_i,
   input  logic              clr_ferr_i,
   input  logic              clr_ovr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              rxfull_o,
   output logic              ferr_o,
   output logic              ovr_o,
   output logic              hw_clr_mpie_o
);
   logic wake_armed, frame_seen, accept;

   assign wake_armed    = ctrl_i.mpie & mp_mode_i & async_mode_i;
   assign frame_seen    = frm_valid_i & ctrl_i.re;
   assign accept        = frame_seen & (~wake_armed | frm_mpb_i);
   assign hw_clr_mpie_o = frame_seen & wake_armed & frm_mpb_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_o   <= '0;
         rxfull_o <= 1'b0;
         ferr_o   <= 1'b0;
         ovr_o    <= 1'b0;
      end else begin
         if (accept) data_o <= frm_data_i;
         rxfull_o <= accept ? 1'b1 : (rxfull_o & ~clr_rxfull_i);
         ferr_o   <= (accept & frm_ferr_i) | (ferr_o & ~clr_ferr_i);
         ovr_o    <= (accept & frm_ovr_i)  | (ovr_o  & ~clr_ovr_i);
      end
   end
endmodule

// File: rtl/uart_mpf_irq.sv
module uart_mpf_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tx_empty_i,
   input  logic tie_i,
   input  logic rxfull_i,
   input  logic ferr_i,
   input  logic ovr_i,
   input  logic rie_i,
   output logic irq_tx_o,
   output logic irq_rx_o,
   output logic irq_err_o
);
   logic [2:0] req;
   assign req = {tx_empty_i & tie_i, rxfull_i & rie_i, (ferr_i | ovr_i) & rie_i};

   generate
      if (IRQ_REG) begin : g_reg
         logic [2:0] req_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) req_q <= '0;
            else         req_q <= req;
         end
         assign {irq_tx_o, irq_rx_o, irq_err_o} = req_q;
      end else begin : g_comb
         assign {irq_tx_o, irq_rx_o, irq_err_o} = req;
      end
   endgenerate
endmodule

// File: rtl/uart_mp_rx_filter.sv
module uart_mp_rx_filter
   import uart_mpf_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [CW_W-1:0]   bus_wdata_i,
   output logic [CW_W-1:0]   bus_rdata_o,
   input  logic              mp_mode_i,
   input  logic              async_mode_i,
   input  logic              tx_empty_i,
   input  logic              frm_valid_i,
   input  logic [DATA_W-1:0] frm_data_i,
   input  logic              frm_mpb_i,
   input  logic              frm_ferr_i,
   input  logic              frm_ovr_i,
   input  logic              clr_rxfull_i,
   input  logic              clr_ferr_i,
   input  logic              clr_ovr_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rxfull_o,
   output logic              ferr_o,
   output logic              ovr_o,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic [CKS_W-1:0]  clk_sel_o,
   output logic              irq_tx_o,
   output logic              irq_rx_o,
   output logic              irq_err_o
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("DATA_W must lie between 5 and 9");
      end
   endgenerate

   ctrl_t ctrl;
   logic  hw_clr_mpie;

   uart_mpf_ctrl_reg u_ctrl (
      .clk_i, .rst_ni,
      .we_i          (bus_we_i),
      .wdata_i       (bus_wdata_i),
      .hw_clr_mpie_i (hw_clr_mpie),
      .ctrl_o        (ctrl),
      .rdata_o       (bus_rdata_o)
   );

   uart_mpf_rx_gate #(.DATA_W(DATA_W)) u_gate (
      .clk_i, .rst_ni,
      .ctrl_i        (ctrl),
      .mp_mode_i, .async_mode_i,
      .frm_valid_i, .frm_data_i, .frm_mpb_i, .frm_ferr_i, .frm_ovr_i,
      .clr_rxfull_i, .clr_ferr_i, .clr_ovr_i,
      .data_o        (rx_data_o),
      .rxfull_o, .ferr_o, .ovr_o,
      .hw_clr_mpie_o (hw_clr_mpie)
   );

   uart_mpf_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk_i, .rst_ni,
      .tx_empty_i,
      .tie_i     (ctrl.tie),
      .rxfull_i  (rxfull_o),
      .ferr_i    (ferr_o),
      .ovr_i     (ovr_o),
      .rie_i     (ctrl.rie),
      .irq_tx_o, .irq_rx_o, .irq_err_o
   );

   assign tx_en_o   = ctrl.te;
   assign rx_en_o   = ctrl.re;
   assign clk_sel_o = ctrl.cks;
endmodule

// File: rtl/uart_mp_rx_filter_chk.sv
module uart_mp_rx_filter_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [7:0]        bus_rdata_o,
   input logic              mp_mode_i,
   input logic              async_mode_i,
   input logic              tx_empty_i,
   input logic              frm_valid_i,
   input logic              frm_mpb_i,
   input logic              clr_rxfull_i,
   input logic              clr_ferr_i,
   input logic              clr_ovr_i,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              rxfull_o,
   input logic              ferr_o,
   input logic              ovr_o,
   input logic              irq_tx_o,
   input logic              irq_rx_o,
   input logic              irq_err_o
);
   logic armed;
   assign armed = bus_rdata_o[3] & mp_mode_i & async_mode_i;

   a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_rdata_o[2] == 1'b0);

   a_r6_skip_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frm_valid_i && bus_rdata_o[4] && armed && !frm_mpb_i |=> $stable(rx_data_o));

   a_r7_address_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frm_valid_i && bus_rdata_o[4] && armed && frm_mpb_i |=> !bus_rdata_o[3] && rxfull_o);

   a_r9_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frm_valid_i && !bus_rdata_o[4] |=> $stable(rx_data_o));

   a_r11_rxfull_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rxfull_o && !clr_rxfull_i |=> rxfull_o);

   a_r11_ferr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ferr_o && !clr_ferr_i |=> ferr_o);

   a_r11_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_o && !clr_ovr_i |=> ovr_o);

   generate
      if (!IRQ_REG) begin : g_comb_chk
         a_r4_tx_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_tx_o == (tx_empty_i && bus_rdata_o[7]));
         a_r5_rx_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_rx_o == (rxfull_o && bus_rdata_o[6]));
         a_r5_err_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_err_o == ((ferr_o || ovr_o) && bus_rdata_o[6]));
      end
   endgenerate
endmodule

bind uart_mp_rx_filter uart_mp_rx_filter_chk #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .bus_rdata_o(bus_rdata_o),
   .mp_mode_i(mp_mode_i), .async_mode_i(async_mode_i), .tx_empty_i(tx_empty_i),
   .frm_valid_i(frm_valid_i), .frm_mpb_i(frm_mpb_i),
   .clr_rxfull_i(clr_rxfull_i), .clr_ferr_i(clr_ferr_i), .clr_ovr_i(clr_ovr_i),
   .rx_data_o(rx_data_o), .rxfull_o(rxfull_o), .ferr_o(ferr_o), .ovr_o(ovr_o),
   .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o)
);

// File: tb/uart_mp_rx_filter_tb_top.sv
`timescale 1ns/1ps
module uart_mp_rx_filter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       mp = 1'b0, as = 1'b0, txe = 1'b0;
   logic       fv = 1'b0, fmpb = 1'b0, fferr = 1'b0, fovr = 1'b0;
   logic [7:0] fdata = '0;
   logic       c_rf = 1'b0, c_fe = 1'b0, c_ov = 1'b0;
   logic [7:0] rxd;
   logic       rxfull, ferr, ovr, txen, rxen, itx, irx, ierr;
   logic [1:0] cks;

   always #2.5 clk = ~clk;

   uart_mp_rx_filter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .mp_mode_i(mp), .async_mode_i(as), .tx_empty_i(txe),
      .frm_valid_i(fv), .frm_data_i(fdata), .frm_mpb_i(fmpb), .frm_ferr_i(fferr), .frm_ovr_i(fovr),
      .clr_rxfull_i(c_rf), .clr_ferr_i(c_fe), .clr_ovr_i(c_ov),
      .rx_data_o(rxd), .rxfull_o(rxfull), .ferr_o(ferr), .ovr_o(ovr),
      .tx_en_o(txen), .rx_en_o(rxen), .clk_sel_o(cks),
      .irq_tx_o(itx), .irq_rx_o(irx), .irq_err_o(ierr)
   );

   typedef struct {
      logic [7:0] rd;
      logic [7:0] d;
      logic [2:0] fl;
      logic [2:0] irq;
      logic [1:0] cs;
      logic [1:0] en;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_fail = 0;

   // reference state built from the requirements
   logic [7:0] m_cw = '0, m_d = '0;
   logic       m_rf = 0, m_fe = 0, m_ov = 0;

   task automatic push_exp(input string tag);
      exp_t e;
      e.rd  = m_cw;
      e.d   = m_d;
      e.fl  = {m_rf, m_fe, m_ov};
      e.irq = {txe & m_cw[7], m_rf & m_cw[6], (m_fe | m_ov) & m_cw[6]};
      e.cs  = m_cw[1:0];
      e.en  = {m_cw[5], m_cw[4]};
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic step(input logic w, input logic [7:0] wd,
                       input logic v, input logic [7:0] dd, input logic mb,
                       input logic fe, input logic ov, input logic [2:0] clr,
                       input string tag);
      logic armed, acc, hwclr;
      we = w; wdata = wd; fv = v; fdata = dd; fmpb = mb; fferr = fe; fovr = ov;
      {c_rf, c_fe, c_ov} = clr;
      armed = m_cw[3] & mp & as;
      acc   = v & m_cw[4] & (!armed | mb);
      hwclr = v & m_cw[4] & armed & mb;
      if (w) m_cw = wd & 8'hFB;
      if (hwclr) m_cw[3] = 1'b0;
      if (acc) m_d = dd;
      m_rf = acc | (m_rf & !clr[2]);
      m_fe = (acc & fe) | (m_fe & !clr[1]);
      m_ov = (acc & ov) | (m_ov & !clr[0]);
      @(posedge clk);
      #1;
      we = 0; fv = 0; fmpb = 0; fferr = 0; fovr = 0; c_rf = 0; c_fe = 0; c_ov = 0;
      push_exp(tag);
      @(negedge clk);
      #1;
   endtask

   task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "rdata", rdata, e.rd);
            cmp(e.tag, "rxdata", rxd, e.d);
            cmp(e.tag, "flags", {5'b0, rxfull, ferr, ovr}, {5'b0, e.fl});
            cmp(e.tag, "irq", {5'b0, itx, irx, ierr}, {5'b0, e.irq});
            cmp(e.tag, "clksel", {6'b0, cks}, {6'b0, e.cs});
            cmp(e.tag, "enables", {6'b0, txen, rxen}, {6'b0, e.en});
         end
      end
   end

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      push_exp("R1 reset");
      @(negedge clk); #1;
      // R2 R3 R12 R4: full write, reserved bit dropped
      txe = 1'b1;
      step(1, 8'hFF, 0, 0, 0, 0, 0, 3'b000, "R2 R3 R12 R4 write all ones");
      step(1, 8'h01, 0, 0, 0, 0, 0, 3'b000, "R3 code 1");
      step(1, 8'h02, 0, 0, 0, 0, 0, 3'b000, "R3 code 2 R4 tie off");
      step(1, 8'h10, 0, 0, 0, 0, 0, 3'b000, "R12 rx only");
      // R5: frame taken with rie off, then enable
      step(0, 0, 1, 8'hA5, 0, 0, 0, 3'b000, "R5 frame rie off");
      step(1, 8'h50, 0, 0, 0, 0, 0, 3'b000, "R5 rie on");
      step(0, 0, 1, 8'h5A, 0, 1, 0, 3'b000, "R5 framing error irq");
      // R11: sticky, clears, set beats clear
      step(0, 0, 0, 0, 0, 0, 0, 3'b000, "R11 idle sticky");
      step(0, 0, 1, 8'h11, 0, 0, 1, 3'b111, "R11 set wins over clear");
      step(0, 0, 0, 0, 0, 0, 0, 3'b111, "R11 clear all");
      // R6/R7: armed wake-up mode
      mp = 1'b1; as = 1'b1;
      step(1, 8'h58, 0, 0, 0, 0, 0, 3'b000, "R6 arm");
      step(0, 0, 1, 8'h77, 0, 1, 1, 3'b000, "R6 data frame dropped");
      step(0, 0, 1, 8'h78, 0, 0, 0, 3'b000, "R6 second drop");
      step(0, 0, 1, 8'h3C, 1, 1, 0, 3'b000, "R7 address frame taken");
      step(0, 0, 1, 8'h44, 0, 0, 0, 3'b100, "R7 normal reception resumed");
      // R8: mpie with multiprocessor mode off, then async off
      mp = 1'b0;
      step(1, 8'h58, 0, 0, 0, 0, 0, 3'b111, "R8 mpie set mp off");
      step(0, 0, 1, 8'h66, 0, 0, 0, 3'b000, "R8 frame taken, bit3 kept");
      mp = 1'b1; as = 1'b0;
      step(0, 0, 1, 8'h67, 1, 0, 0, 3'b000, "R8 sync mode, bit3 kept");
      // R9: receiver disabled
      as = 1'b1;
      step(1, 8'h48, 0, 0, 0, 0, 0, 3'b100, "R9 re off");
      step(0, 0, 1, 8'h99, 1, 1, 1, 3'b000, "R9 frame ignored");
      // R10: write collides with hardware clear
      step(1, 8'h58, 0, 0, 0, 0, 0, 3'b000, "R10 arm");
      step(1, 8'hDB, 1, 8'hC3, 1, 0, 0, 3'b000, "R10 hw clear beats write");
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule